// File: doc/BRIEF.md
# Escape-time fractal iteration engine

This block walks a rectangular frame pixel by pixel and, for each pixel, runs the quadratic map z ← z² + c in signed fixed point until the point escapes or an iteration limit is hit. It writes the resulting 8-bit count to a pixel-write port, one strobe per pixel. A colour lookup or display path downstream turns the counts into an image.

Software-side logic sets the frame size, the row and column offsets, a per-pixel step (the reciprocal of the zoom, precomputed), the constant c, the squared escape bound, the iteration limit and the mode. It then pulses `start_i`. In Julia mode the pixel gives the starting z and c is the configured constant. In Mandelbrot mode the pixel gives both the starting z and c. Coordinates are signed Q4.28. Squares and cross products keep their full integer part for the escape test. The next z is truncated back to Q4.28.

Top module: `fractal_engine`

## Requirements
- R1: While reset is asserted and after it is released, `busy_o`, `done_o` and `wr_en_o` are low.
- R2: In Julia mode (`mode_i`=0) the starting real part is (row − `row_off_i`)·`step_i` and the starting imaginary part is (column − `col_off_i`)·`step_i`, taken modulo 2^32 as Q4.28. c is (`c_re_i`, `c_im_i`).
- R3: One iteration forms xx = (x·x)>>>28, yy = (y·y)>>>28 and xy = (x·y)>>>28 at 64-bit width. It then sets x ← low 32 bits of xx − yy + c_re and y ← low 32 bits of 2·xy + c_im. It records the magnitude xx + yy of the z the squares came from.
- R4: Before each iteration the engine stops if count+1 ≥ `max_iter_i` or if the recorded magnitude (0 before the first iteration) is ≥ `bound_i`. The written value is the count at that point, so it lies in 0..max−1, and it is 0 for a limit of 0 or 1.
- R5: In Mandelbrot mode (`mode_i`=1) c equals the pixel coordinate of R2, and z starts at that same coordinate.
- R6: Pixels are visited row by row, columns ascending within a row. Each pixel is written exactly once at address column + row·width.
- R7: Each pixel takes n+3 cycles, where n is its count. There is one load cycle, n+1 iteration cycles and a final cycle that carries the write strobe. No two strobes are adjacent.
- R8: `done_o` is high for exactly the one cycle after the last write strobe, with `busy_o` still high. `busy_o` is low in the next cycle.
- R9: The mode and all configuration inputs are sampled only in the cycle where `start_i` is accepted in idle. A `start_i` pulse or a configuration change while busy does not alter the frame in progress.
- R10: `busy_o` rises in the cycle after `start_i` is seen high in idle. Width and height must be at least 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Starts a frame when idle |
| mode_i | input | 1 | 0 Julia, 1 Mandelbrot |
| width_i | input | DIM_W | Frame width in pixels |
| height_i | input | DIM_W | Frame height in pixels |
| col_off_i | input | DIM_W | Column offset subtracted before scaling |
| row_off_i | input | DIM_W | Row offset subtracted before scaling |
| step_i | input | CW | Q4.28 coordinate step per pixel (1/zoom) |
| c_re_i | input | CW | Q4.28 real part of constant (Julia) |
| c_im_i | input | CW | Q4.28 imaginary part of constant (Julia) |
| bound_i | input | 2·CW−FRAC | Squared escape bound, Q8.28 |
| max_iter_i | input | CNT_W | Iteration limit |
| busy_o | output | 1 | Frame in progress |
| done_o | output | 1 | One-cycle frame completion pulse |
| wr_en_o | output | 1 | Pixel write strobe |
| wr_addr_o | output | 2·DIM_W | Pixel address |
| wr_data_o | output | CNT_W | Iteration count |

## Verification
A corrupted z, magnitude or count register changes the length of that pixel's iteration run. The write strobe then moves by at least one cycle, usually on the pixel where the fault happens, well before its data is compared. A wrong row, column or address counter shows up at the next strobe, either as a wrong address or as a count computed from the wrong coordinate. A fault in the control sequence shows up as a misplaced `done_o` or `busy_o` within a cycle. The bench predicts every cycle's strobe, address, data, done and busy, so any of these faults is caught at the first cycle where the ports differ.

// File: rtl/frac_pkg.sv
package frac_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOAD,
    ST_ITER,
    ST_WRITE,
    ST_DONE
  } eng_state_e;
endpackage

// File: rtl/frac_coord.sv
module frac_coord #(
  parameter int DIM_W = 10,
  parameter int CW    = 32
) (
  input  logic [DIM_W-1:0]     idx_i,
  input  logic [DIM_W-1:0]     off_i,
  input  logic signed [CW-1:0] step_i,
  output logic signed [CW-1:0] coord_o
);
  logic signed [DIM_W:0] diff;

  assign diff    = $signed({1'b0, idx_i}) - $signed({1'b0, off_i});
  // low CW bits of the product are exact modulo 2^CW
  assign coord_o = CW'(diff) * step_i;
endmodule

// File: rtl/frac_scan.sv
module frac_scan #(
  parameter int DIM_W  = 10,
  parameter int ADDR_W = 2 * DIM_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              adv_i,
  input  logic [DIM_W-1:0]  width_i,
  input  logic [DIM_W-1:0]  height_i,
  output logic [DIM_W-1:0]  row_o,
  output logic [DIM_W-1:0]  col_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              last_o
);
  logic col_end;

  assign col_end = (col_o == width_i - DIM_W'(1));
  assign last_o  = col_end && (row_o == height_i - DIM_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      row_o  <= '0;
      col_o  <= '0;
      addr_o <= '0;
    end else if (clr_i) begin
      row_o  <= '0;
      col_o  <= '0;
      addr_o <= '0;
    end else if (adv_i) begin
      addr_o <= addr_o + ADDR_W'(1);
      if (col_end) begin
        col_o <= '0;
        row_o <= row_o + DIM_W'(1);
      end else begin
        col_o <= col_o + DIM_W'(1);
      end
    end
  end
endmodule

// File: rtl/frac_iter.sv
module frac_iter #(
  parameter int CW    = 32,
  parameter int FRAC  = 28,
  parameter int CNT_W = 8,
  localparam int PW   = 2 * CW,
  localparam int SQ_W = 2 * CW - FRAC
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   load_i,
  input  logic                   adv_i,
  input  logic signed [CW-1:0]   z_re_i,
  input  logic signed [CW-1:0]   z_im_i,
  input  logic signed [CW-1:0]   c_re_i,
  input  logic signed [CW-1:0]   c_im_i,
  input  logic [SQ_W-1:0]        bound_i,
  input  logic [CNT_W-1:0]       max_i,
  output logic                   stop_o,
  output logic [CNT_W-1:0]       cnt_o
);
  logic signed [CW-1:0] x_q, y_q;
  logic signed [PW-1:0] rad_q;
  logic signed [PW-1:0] xw, yw, xx, yy, xy, mag;
  logic signed [CW-1:0] x_nx, y_nx;
  logic [CNT_W:0]       cnt_p1;

  assign xw  = PW'(x_q);
  assign yw  = PW'(y_q);
  assign xx  = (xw * xw) >>> FRAC;
  assign yy  = (yw * yw) >>> FRAC;
  assign xy  = (xw * yw) >>> FRAC;
  assign mag = xx + yy;
  // the same squares feed the next z and the escape magnitude
  assign x_nx = CW'(xx - yy) + c_re_i;
  assign y_nx = CW'(xy <<< 1) + c_im_i;

  assign cnt_p1 = {1'b0, cnt_o} + (CNT_W + 1)'(1);
  assign stop_o = (cnt_p1 >= {1'b0, max_i}) ||
                  (rad_q >= $signed({{(PW - SQ_W){1'b0}}, bound_i}));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      x_q   <= '0;
      y_q   <= '0;
      rad_q <= '0;
      cnt_o <= '0;
    end else if (load_i) begin
      x_q   <= z_re_i;
      y_q   <= z_im_i;
      rad_q <= '0;
      cnt_o <= '0;
    end else if (adv_i) begin
      x_q   <= x_nx;
      y_q   <= y_nx;
      rad_q <= mag;
      cnt_o <= cnt_o + CNT_W'(1);
    end
  end
endmodule

// File: rtl/fractal_engine.sv
module fractal_engine
  import frac_pkg::*;
#(
  parameter int DIM_W  = 10,
  parameter int CW     = 32,
  parameter int FRAC   = 28,
  parameter int CNT_W  = 8,
  localparam int ADDR_W = 2 * DIM_W,
  localparam int SQ_W   = 2 * CW - FRAC
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  start_i,
  input  logic                  mode_i,
  input  logic [DIM_W-1:0]      width_i,
  input  logic [DIM_W-1:0]      height_i,
  input  logic [DIM_W-1:0]      col_off_i,
  input  logic [DIM_W-1:0]      row_off_i,
  input  logic signed [CW-1:0]  step_i,
  input  logic signed [CW-1:0]  c_re_i,
  input  logic signed [CW-1:0]  c_im_i,
  input  logic [SQ_W-1:0]       bound_i,
  input  logic [CNT_W-1:0]      max_iter_i,
  output logic                  busy_o,
  output logic                  done_o,
  output logic                  wr_en_o,
  output logic [ADDR_W-1:0]     wr_addr_o,
  output logic [CNT_W-1:0]      wr_data_o
);
  eng_state_e           state_q;
  logic                 mode_q;
  logic [DIM_W-1:0]     width_q, height_q, col_off_q, row_off_q;
  logic signed [CW-1:0] step_q, c_re_q, c_im_q;
  logic [SQ_W-1:0]      bound_q;
  logic [CNT_W-1:0]     max_q;

  logic                 accept, sc_last, it_stop;
  logic [DIM_W-1:0]     row, col;
  logic signed [CW-1:0] pix_re, pix_im, c_re_sel, c_im_sel;

  assign accept = (state_q == ST_IDLE) && start_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      mode_q    <= 1'b0;
      width_q   <= '0;
      height_q  <= '0;
      col_off_q <= '0;
      row_off_q <= '0;
      step_q    <= '0;
      c_re_q    <= '0;
      c_im_q    <= '0;
      bound_q   <= '0;
      max_q     <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (start_i) begin
          mode_q    <= mode_i;
          width_q   <= width_i;
          height_q  <= height_i;
          col_off_q <= col_off_i;
          row_off_q <= row_off_i;
          step_q    <= step_i;
          c_re_q    <= c_re_i;
          c_im_q    <= c_im_i;
          bound_q   <= bound_i;
          max_q     <= max_iter_i;
          state_q   <= ST_LOAD;
        end
        ST_LOAD:  state_q <= ST_ITER;
        ST_ITER:  if (it_stop) state_q <= ST_WRITE;
        ST_WRITE: state_q <= sc_last ? ST_DONE : ST_LOAD;
        ST_DONE:  state_q <= ST_IDLE;
        default:  state_q <= ST_IDLE;
      endcase
    end
  end

  frac_scan #(.DIM_W(DIM_W), .ADDR_W(ADDR_W)) u_scan (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (accept),
    .adv_i    (state_q == ST_WRITE),
    .width_i  (width_q),
    .height_i (height_q),
    .row_o    (row),
    .col_o    (col),
    .addr_o   (wr_addr_o),
    .last_o   (sc_last)
  );

  // real axis follows rows, imaginary axis follows columns
  frac_coord #(.DIM_W(DIM_W), .CW(CW)) u_coord_re (
    .idx_i   (row),
    .off_i   (row_off_q),
    .step_i  (step_q),
    .coord_o (pix_re)
  );

  frac_coord #(.DIM_W(DIM_W), .CW(CW)) u_coord_im (
    .idx_i   (col),
    .off_i   (col_off_q),
    .step_i  (step_q),
    .coord_o (pix_im)
  );

  assign c_re_sel = mode_q ? pix_re : c_re_q;
  assign c_im_sel = mode_q ? pix_im : c_im_q;

  frac_iter #(.CW(CW), .FRAC(FRAC), .CNT_W(CNT_W)) u_iter (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (state_q == ST_LOAD),
    .adv_i   ((state_q == ST_ITER) && !it_stop),
    .z_re_i  (pix_re),
    .z_im_i  (pix_im),
    .c_re_i  (c_re_sel),
    .c_im_i  (c_im_sel),
    .bound_i (bound_q),
    .max_i   (max_q),
    .stop_o  (it_stop),
    .cnt_o   (wr_data_o)
  );

  assign busy_o  = (state_q != ST_IDLE);
  assign done_o  = (state_q == ST_DONE);
  assign wr_en_o = (state_q == ST_WRITE);
endmodule

// File: rtl/frac_checker.sv
module frac_checker #(
  parameter int CNT_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             busy_i,
  input logic             done_i,
  input logic             wr_en_i,
  input logic [CNT_W-1:0] wr_data_i,
  input logic [CNT_W-1:0] max_i
);
  assert_idle_quiet_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_i |-> (!wr_en_i && !done_i));

  assert_count_range_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && max_i != '0) |-> (wr_data_i < max_i));

  assert_single_strobe_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> !wr_en_i);

  assert_done_after_write_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |-> $past(wr_en_i));

  assert_done_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> (!done_i && !busy_i));

  assert_excl_outputs_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({wr_en_i, done_i}));
endmodule

bind fractal_engine frac_checker #(.CNT_W(CNT_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .busy_i    (busy_o),
  .done_i    (done_o),
  .wr_en_i   (wr_en_o),
  .wr_data_i (wr_data_o),
  .max_i     (max_q)
);

// File: tb/sim_fractal_engine.sv
module sim_fractal_engine;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        mode = 1'b0;
  logic [9:0]  width = 10'd1, height = 10'd1, col_off = '0, row_off = '0;
  logic signed [31:0] step = '0, c_re = '0, c_im = '0;
  logic [35:0] bound = '0;
  logic [7:0]  max_iter = '0;
  logic        busy, done, wr_en;
  logic [19:0] wr_addr;
  logic [7:0]  wr_data;

  int total = 0;
  int bad = 0;
  int cyc = 0;

  int e_wr[$], e_addr[$], e_data[$], e_done[$], e_busy[$];

  always #2 clk = ~clk;

  fractal_engine u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .mode_i(mode),
    .width_i(width), .height_i(height), .col_off_i(col_off), .row_off_i(row_off),
    .step_i(step), .c_re_i(c_re), .c_im_i(c_im), .bound_i(bound),
    .max_iter_i(max_iter), .busy_o(busy), .done_o(done), .wr_en_o(wr_en),
    .wr_addr_o(wr_addr), .wr_data_o(wr_data)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      total++;
      bad++;
      $display("FAIL R7 watchdog expired: got %0d cycles expected fewer", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(string tag, string what, longint act, longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: got %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic longint coord(int idx, int off, longint stp);
    return longint'(int'(longint'(idx - off) * stp));
  endfunction

  // behavioural escape-time loop (R3, R4)
  function automatic int ref_count(longint zr, longint zi, longint cr, longint ci,
                                   int mx, longint bnd);
    int n = 0;
    longint rad = 0;
    longint x = zr;
    longint y = zi;
    while (!((n + 1 >= mx) || (rad >= bnd))) begin
      longint xx, yy, xy;
      xx  = (x * x) >>> 28;
      yy  = (y * y) >>> 28;
      xy  = (x * y) >>> 28;
      rad = xx + yy;
      x   = longint'(int'(xx - yy + cr));
      y   = longint'(int'(2 * xy + ci));
      n++;
    end
    return n;
  endfunction

  task automatic push(int wr, int addr, int data, int dn, int bz);
    e_wr.push_back(wr); e_addr.push_back(addr); e_data.push_back(data);
    e_done.push_back(dn); e_busy.push_back(bz);
  endtask

  task automatic build_model();
    for (int r = 0; r < int'(height); r++) begin
      for (int c = 0; c < int'(width); c++) begin
        longint zr = coord(r, int'(row_off), longint'(step));
        longint zi = coord(c, int'(col_off), longint'(step));
        longint kr = mode ? zr : longint'(c_re);
        longint ki = mode ? zi : longint'(c_im);
        int n = ref_count(zr, zi, kr, ki, int'(max_iter), longint'(bound));
        for (int k = 0; k < n + 2; k++) push(0, 0, 0, 0, 1);
        push(1, c + r * int'(width), n, 0, 1);   // R6 address
      end
    end
    push(0, 0, 0, 1, 1);                          // R8 done pulse
    push(0, 0, 0, 0, 0);                          // R8 busy falls
  endtask

  task automatic run_frame(string tag, bit mid_pulse);
    int idx = 0;
    e_wr.delete(); e_addr.delete(); e_data.delete(); e_done.delete(); e_busy.delete();
    build_model();
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (e_wr.size() > 0) begin
      int w = e_wr.pop_front();
      int a = e_addr.pop_front();
      int d = e_data.pop_front();
      int dn = e_done.pop_front();
      int bz = e_busy.pop_front();
      chk("R7", "strobe", longint'(wr_en), longint'(w));
      if (w != 0) begin
        chk("R6", "address", longint'(wr_addr), longint'(a));
        chk(tag, "count", longint'(wr_data), longint'(d));
      end
      chk("R8", "done", longint'(done), longint'(dn));
      chk("R8", "busy", longint'(busy), longint'(bz));
      if (mid_pulse && idx == 5) begin
        // R9: new start and config while busy must be ignored
        start = 1'b1; mode = ~mode; width = width + 10'd3; c_re = c_re + 32'sd1000000;
      end else begin
        start = 1'b0;
      end
      idx++;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", "busy in reset", longint'(busy), 0);
    chk("R1", "strobe in reset", longint'(wr_en), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "busy after reset", longint'(busy), 0);
    chk("R1", "done after reset", longint'(done), 0);
    chk("R1", "strobe after reset", longint'(wr_en), 0);

    // R2 Julia frame, radius 2, limit 128
    mode = 1'b0; width = 10'd8; height = 10'd6; col_off = 10'd4; row_off = 10'd3;
    step = 32'sd89478485; c_re = 32'sd76504105; c_im = 32'sd2684355;
    bound = 36'd1073741824; max_iter = 8'd128;
    run_frame("R2", 1'b0);

    // R5 / R10 Mandelbrot frame (mode_i=1), squared bound 16
    mode = 1'b1; width = 10'd6; height = 10'd5; col_off = 10'd3; row_off = 10'd3;
    step = 32'sd134217728; bound = 36'd4294967296; max_iter = 8'd32;
    run_frame("R5", 1'b0);

    // R4 limits of 1 and 0 give zero counts
    mode = 1'b0; width = 10'd3; height = 10'd2; max_iter = 8'd1;
    run_frame("R4", 1'b0);
    width = 10'd2; height = 10'd1; max_iter = 8'd0;
    run_frame("R4", 1'b0);

    // R3 coarse step, large coordinates, long limit
    width = 10'd5; height = 10'd4; col_off = 10'd0; row_off = 10'd0;
    step = 32'sd268435456; c_re = -32'sd134217728; c_im = 32'sd67108864;
    bound = 36'd1073741824; max_iter = 8'd255;
    run_frame("R3", 1'b0);

    // R9 start pulse and config change mid-frame
    width = 10'd4; height = 10'd4; col_off = 10'd2; row_off = 10'd2;
    step = 32'sd89478485; c_re = 32'sd76504105; c_im = 32'sd2684355; max_iter = 8'd64;
    run_frame("R9", 1'b1);

    // R6 single-column Mandelbrot frame
    mode = 1'b1; width = 10'd1; height = 10'd3; col_off = 10'd0; row_off = 10'd1;
    step = 32'sd134217728; bound = 36'd4294967296; max_iter = 8'd16;
    run_frame("R6", 1'b0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule